// File: doc/BRIEF.md
# Stream Source Selector and Sample Formatter

This block is the input stage of one acquisition output stream. A 5-bit source code picks one of up to thirty incoming sample channels, or a built-in incrementing test counter, or nothing at all. The chosen sample passes through a formatter that keeps the bits at and below a programmable extension position. The bits above that position are filled with copies of the bit at that position in signed mode, or with zeros in unsigned mode.

The formatted result leaves as one 32-bit word per valid input sample. In half-width mode the low 16 bits of two consecutive samples are packed into one 32-bit word, with the earlier sample in the low half. A registered flag reports whether the selected lane currently delivers valid data.

A small state machine tracks the packing. Its states are ST_OFF (source code 0), ST_WIDE (full-width words), ST_PAIR_LO (half-width mode, no half held) and ST_PAIR_HI (half-width mode, one half held). Any state goes to ST_OFF when the code is 0 and to ST_WIDE when the wide bit is set. In half-width mode, ST_PAIR_LO moves to ST_PAIR_HI on a valid sample. ST_PAIR_HI returns to ST_PAIR_LO on a valid sample and emits the packed word. Each half-width state holds when no valid sample arrives. Entering half-width mode from ST_OFF or ST_WIDE always lands in ST_PAIR_LO.

Top module: `stream_fmt_top`

## Requirements
- R1: After reset, out_valid, lane_ok and out_data are all zero.
- R2: With source code 0 the block produces no valid output and lane_ok is low, whatever the channel inputs do.
- R3: With source code 1 in full-width mode, a valid word appears every cycle. Its value is the test counter, which starts at 0 after reset and increases by one per sample.
- R4: Source code k, with 2 <= k <= N_CH+1, selects channel k-2. One clock after the edge at which that channel's valid bit is sampled high, out_valid and lane_ok are high. When that valid bit is low, both are low.
- R5: A source code above N_CH+1 names no implemented channel and gives out_valid and lane_ok low.
- R6: In signed mode, output bits above the extension position fmt_ext_pos equal the sample bit at that position.
- R7: In unsigned mode, output bits above the extension position are zero.
- R8: An extension position of 31 passes a full-width sample unchanged in both modes.
- R9: With fmt_wide low, two valid samples give one output word {second[15:0], first[15:0]}. out_valid stays low for the first sample and for any idle cycles between the two.
- R10: Entering half-width mode from full-width mode or from the disabled state discards any held half, so the next sample becomes the low half.
- R11: While the source is not the test counter, the counter holds its value, and test output resumes from that value.
- R12: In half-width test mode the counter advances once per sample, so a packed word is {n+1, n} in its two 16-bit halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel | input | 5 | Source code: 0 off, 1 test counter, k>=2 channel k-2 |
| fmt_ext_pos | input | 5 | Bit position from which the upper bits are filled |
| fmt_wide | input | 1 | 1 selects 32-bit words, 0 selects packed 16-bit halves |
| fmt_signed | input | 1 | 1 sign-fills, 0 zero-fills |
| ch_data | input | N_CH*32 | Channel samples, channel i at bits [32*i+31:32*i] |
| ch_valid | input | N_CH | Per-channel sample valid |
| out_data | output | 32 | Formatted output word |
| out_valid | output | 1 | out_data holds a new word |
| lane_ok | output | 1 | Selected source was valid at the last edge |

## Verification
The packing state is the only hidden state that can go wrong without showing at once. A wrongly held half shows up at the first packed word after a mode change, as a word that arrives one sample early or that carries a stale low half. A wrong test counter shows on the very next test word, and a wrong source decode shows one clock after the code is applied, as a valid pulse or a wrong lane_ok level. Every output is registered once, so each fault is visible at the port one cycle after the edge that caused it.

// File: rtl/stream_fmt_pkg.sv
package stream_fmt_pkg;
    localparam int SEL_W    = 5;
    localparam int WORD_W   = 32;
    localparam int HALF_W   = WORD_W / 2;
    localparam int POS_W    = $clog2(WORD_W);
    localparam int SEL_OFF  = 0;
    localparam int SEL_TEST = 1;
    localparam int SEL_CH0  = 2;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_WIDE,
        ST_PAIR_LO,
        ST_PAIR_HI
    } pack_state_t;
endpackage

// File: rtl/stream_src_mux.sv
module stream_src_mux
    import stream_fmt_pkg::*;
#(
    parameter int N_CH = 30,
    parameter int DW   = WORD_W
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic [N_CH*DW-1:0] ch_data,
    input  logic [N_CH-1:0]    ch_valid,
    input  logic [DW-1:0]      test_word,
    output logic [DW-1:0]      pick,
    output logic               pick_vld
);
    logic [N_CH-1:0] hit;

    for (genvar g = 0; g < N_CH; g++) begin : g_hit
        assign hit[g] = (sel == SEL_W'(g + SEL_CH0));
    end

    always_comb begin
        pick     = '0;
        pick_vld = 1'b0;
        if (sel == SEL_W'(SEL_TEST)) begin
            pick     = test_word;
            pick_vld = 1'b1;
        end else begin
            for (int i = 0; i < N_CH; i++) begin
                if (hit[i]) begin
                    pick     = ch_data[i*DW +: DW];
                    pick_vld = ch_valid[i];
                end
            end
        end
    end
endmodule

// File: rtl/stream_sample_fmt.sv
module stream_sample_fmt
    import stream_fmt_pkg::*;
(
    input  logic [WORD_W-1:0] raw,
    input  logic [POS_W-1:0]  pos,
    input  logic              sgn,
    output logic [WORD_W-1:0] fmt
);
    logic [WORD_W-1:0] keep;
    logic              fill;

    always_comb begin
        keep = {WORD_W{1'b1}} >> (POS_W'(WORD_W - 1) - pos);
        fill = sgn & raw[pos];
        fmt  = (raw & keep) | (fill ? ~keep : '0);
    end
endmodule

// File: rtl/stream_test_ctr.sv
module stream_test_ctr
    import stream_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    output logic [WORD_W-1:0] val
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   val <= '0;
        else if (adv) val <= val + 1'b1;
    end
endmodule

// File: rtl/stream_fmt_top.sv
module stream_fmt_top
    import stream_fmt_pkg::*;
#(
    parameter int N_CH = 30
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [4:0]             src_sel,
    input  logic [4:0]             fmt_ext_pos,
    input  logic                   fmt_wide,
    input  logic                   fmt_signed,
    input  logic [N_CH*32-1:0]     ch_data,
    input  logic [N_CH-1:0]        ch_valid,
    output logic [31:0]            out_data,
    output logic                   out_valid,
    output logic                   lane_ok
);
    pack_state_t       state, nxt_state;
    logic [WORD_W-1:0] test_word, pick, fmt;
    logic              pick_vld, test_adv;
    logic [HALF_W-1:0] held, nxt_held;
    logic              emit;
    logic [WORD_W-1:0] emit_word;

    assign test_adv = (src_sel == SEL_W'(SEL_TEST));

    stream_test_ctr u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (test_adv),
        .val   (test_word)
    );

    stream_src_mux #(.N_CH(N_CH), .DW(WORD_W)) u_mux (
        .sel       (src_sel),
        .ch_data   (ch_data),
        .ch_valid  (ch_valid),
        .test_word (test_word),
        .pick      (pick),
        .pick_vld  (pick_vld)
    );

    stream_sample_fmt u_fmt (
        .raw (pick),
        .pos (fmt_ext_pos),
        .sgn (fmt_signed),
        .fmt (fmt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            held  <= '0;
        end else begin
            state <= nxt_state;
            held  <= nxt_held;
        end
    end

    // Next state and word assembly
    always_comb begin
        nxt_state = state;
        nxt_held  = held;
        emit      = 1'b0;
        emit_word = fmt;
        if (src_sel == SEL_W'(SEL_OFF)) begin
            nxt_state = ST_OFF;
        end else if (fmt_wide) begin
            nxt_state = ST_WIDE;
            emit      = pick_vld;
        end else begin
            unique case (state)
                ST_PAIR_HI: begin
                    if (pick_vld) begin
                        emit      = 1'b1;
                        emit_word = {fmt[HALF_W-1:0], held};
                        nxt_state = ST_PAIR_LO;
                    end
                end
                ST_OFF, ST_WIDE, ST_PAIR_LO: begin
                    if (pick_vld) begin
                        nxt_held  = fmt[HALF_W-1:0];
                        nxt_state = ST_PAIR_HI;
                    end else begin
                        nxt_state = ST_PAIR_LO;
                    end
                end
                default: nxt_state = ST_OFF;
            endcase
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            lane_ok   <= 1'b0;
        end else begin
            out_valid <= emit;
            lane_ok   <= pick_vld;
            if (emit) out_data <= emit_word;
        end
    end
endmodule

// File: rtl/stream_fmt_chk.sv
module stream_fmt_chk #(
    parameter int N_CH = 30
) (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  src_sel,
    input logic [4:0]  fmt_ext_pos,
    input logic        fmt_wide,
    input logic        fmt_signed,
    input logic [31:0] out_data,
    input logic        out_valid,
    input logic        lane_ok
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    p_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(src_sel) == 5'd0 |-> !out_valid && !lane_ok);

    p_no_channel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        armed && int'($past(src_sel)) > N_CH + 1 |-> !out_valid && !lane_ok);

    p_test_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
        armed && $past(src_sel) == 5'd1 && $past(fmt_wide) |-> out_valid && lane_ok);

    p_zero_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed && out_valid && $past(fmt_wide) && !$past(fmt_signed)
        |-> (out_data >> ({1'b0, $past(fmt_ext_pos)} + 6'd1)) == 32'd0);

    p_sign_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        armed && out_valid && $past(fmt_wide) && $past(fmt_signed)
        |-> (($signed(out_data) >>> $past(fmt_ext_pos)) == 32'sd0)
         || (($signed(out_data) >>> $past(fmt_ext_pos)) == -32'sd1));

    p_pair_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        armed && out_valid && !$past(fmt_wide) |-> !$past(out_valid));
endmodule

bind stream_fmt_top stream_fmt_chk #(.N_CH(N_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_sel     (src_sel),
    .fmt_ext_pos (fmt_ext_pos),
    .fmt_wide    (fmt_wide),
    .fmt_signed  (fmt_signed),
    .out_data    (out_data),
    .out_valid   (out_valid),
    .lane_ok     (lane_ok)
);

// File: tb/stream_fmt_top_bench.sv
`timescale 1ns/1ps
module stream_fmt_top_bench;
    localparam int NCH = 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [4:0]         src_sel = '0;
    logic [4:0]         fmt_ext_pos = '0;
    logic               fmt_wide = 1'b1;
    logic               fmt_signed = 1'b0;
    logic [NCH*32-1:0]  ch_data = '0;
    logic [NCH-1:0]     ch_valid = '0;
    logic [31:0]        out_data;
    logic               out_valid;
    logic               lane_ok;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stream_fmt_top #(.N_CH(NCH)) u_stream_fmt_top (
        .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .fmt_ext_pos(fmt_ext_pos),
        .fmt_wide(fmt_wide), .fmt_signed(fmt_signed), .ch_data(ch_data),
        .ch_valid(ch_valid), .out_data(out_data), .out_valid(out_valid),
        .lane_ok(lane_ok)
    );

    // {sel, pos, signed, input, expected}, full-width mode
    localparam logic [74:0] VEC [8] = '{
        {5'd2, 5'd31, 1'b1, 32'hDEADBEEF, 32'hDEADBEEF},
        {5'd5, 5'd7,  1'b1, 32'h00000080, 32'hFFFFFF80},
        {5'd5, 5'd7,  1'b0, 32'hFFFFFF80, 32'h00000080},
        {5'd9, 5'd15, 1'b1, 32'h12347FFF, 32'h00007FFF},
        {5'd3, 5'd0,  1'b1, 32'h00000001, 32'hFFFFFFFF},
        {5'd4, 5'd11, 1'b0, 32'hABCDE9A5, 32'h000009A5},
        {5'd6, 5'd3,  1'b1, 32'h0000000C, 32'hFFFFFFFC},
        {5'd7, 5'd31, 1'b0, 32'h80000001, 32'h80000001}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put_ch(input int idx, input logic [31:0] v, input logic vld);
        ch_data[idx*32 +: 32] = v;
        ch_valid[idx] = vld;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R1 lane_ok", {31'b0, lane_ok}, 32'd0);
        chk("R1 out_data", out_data, 32'd0);
        rst_n = 1'b1;

        // vector table, R4 R6 R7 R8
        for (int i = 0; i < 8; i++) begin
            for (int c = 0; c < NCH; c++) put_ch(c, 32'h5A5A0000 + 32'(c), 1'b1);
            src_sel     = VEC[i][74:70];
            fmt_ext_pos = VEC[i][69:65];
            fmt_signed  = VEC[i][64];
            fmt_wide    = 1'b1;
            put_ch(int'(VEC[i][74:70]) - 2, VEC[i][63:32], 1'b1);
            step();
            chk("R4 vector valid", {31'b0, out_valid}, 32'd1);
            chk("R4 vector lane_ok", {31'b0, lane_ok}, 32'd1);
            chk("R6/R7/R8 vector data", out_data, VEC[i][31:0]);
        end

        // R3 test counter from zero
        src_sel = 5'd1; fmt_wide = 1'b1; fmt_ext_pos = 5'd31; fmt_signed = 1'b0;
        for (int n = 0; n < 3; n++) begin
            step();
            chk("R3 test valid", {31'b0, out_valid}, 32'd1);
            chk("R3 test data", out_data, 32'(n));
        end

        // R2 and R11: disabled, counter holds
        src_sel = 5'd0;
        for (int n = 0; n < 3; n++) begin
            step();
            chk("R2 off valid", {31'b0, out_valid}, 32'd0);
            chk("R2 off lane_ok", {31'b0, lane_ok}, 32'd0);
        end
        src_sel = 5'd1;
        step();
        chk("R11 resume data", out_data, 32'd3);

        // R12 half-width test words
        fmt_wide = 1'b0;
        step();
        chk("R12 first half no valid", {31'b0, out_valid}, 32'd0);
        step();
        chk("R12 pair valid", {31'b0, out_valid}, 32'd1);
        chk("R12 pair data", out_data, 32'h00050004);

        // R5 unimplemented code
        src_sel = 5'd12; fmt_wide = 1'b1;
        for (int c = 0; c < NCH; c++) put_ch(c, 32'h11110000 + 32'(c), 1'b1);
        step();
        chk("R5 valid", {31'b0, out_valid}, 32'd0);
        chk("R5 lane_ok", {31'b0, lane_ok}, 32'd0);

        // R4 selected lane invalid
        src_sel = 5'd3;
        ch_valid[1] = 1'b0;
        step();
        chk("R4 invalid lane valid", {31'b0, out_valid}, 32'd0);
        chk("R4 invalid lane lane_ok", {31'b0, lane_ok}, 32'd0);
        ch_valid[1] = 1'b1;
        step();
        chk("R4 lane back", {31'b0, lane_ok}, 32'd1);

        // R9 packing with a gap
        src_sel = 5'd2; fmt_wide = 1'b0; fmt_ext_pos = 5'd15; fmt_signed = 1'b1;
        put_ch(0, 32'h00008001, 1'b1);
        step();
        chk("R9 first half no valid", {31'b0, out_valid}, 32'd0);
        put_ch(0, 32'h0, 1'b0);
        step();
        chk("R9 gap no valid", {31'b0, out_valid}, 32'd0);
        put_ch(0, 32'h00001234, 1'b1);
        step();
        chk("R9 pair valid", {31'b0, out_valid}, 32'd1);
        chk("R9 pair data", out_data, 32'h12348001);

        // R10 wide interlude discards held half
        fmt_ext_pos = 5'd31;
        put_ch(0, 32'h0000AAAA, 1'b1);
        step();
        chk("R10 held A no valid", {31'b0, out_valid}, 32'd0);
        fmt_wide = 1'b1;
        put_ch(0, 32'h0BBBBBBB, 1'b1);
        step();
        chk("R10 wide word", out_data, 32'h0BBBBBBB);
        fmt_wide = 1'b0;
        put_ch(0, 32'h0000CCCC, 1'b1);
        step();
        chk("R10 fresh low no valid", {31'b0, out_valid}, 32'd0);
        put_ch(0, 32'h0000DDDD, 1'b1);
        step();
        chk("R10 pair valid", {31'b0, out_valid}, 32'd1);
        chk("R10 pair data", out_data, 32'hDDDDCCCC);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule